// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking an in-memory translation tree. On each accepted request it fetches a context-table word selected by a context pointer and a context number. It then follows pointer descriptors through up to three table levels until it finds a page entry. That entry can map a 16 MB, 256 KB or 4 KB page. The walker then checks the access type and privilege against the entry's 3-bit access field. When needed, it writes the entry back with its referenced and modified flags updated. It reports the physical address, the page size, a permission mask and a fault code.

The walker uses one memory port one word wide, and has at most one access outstanding at a time. A read is issued with `mem_valid`/`mem_ready` and answered later by a one-cycle `mem_rvalid`. A write completes on its handshake. The memory may stall either handshake for any number of cycles, and the walker holds address, direction and data until it is accepted. Requests arrive on a valid/ready pair. `req_ready` is high only while the walker is idle, so a new request waits until the previous result has been delivered by a one-cycle `done` pulse. When translation is switched off, the address passes through without any memory traffic. In the boot variant of that mode, instruction fetches are steered into a boot-ROM window.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_valid` is 0.
- R2: With `mmu_en` low, a request completes without any memory access: `res_pa` equals the VA, `res_prot` is 3'b111 (bit0 read, bit1 write, bit2 execute), `res_size` is 0 (4 KB) and `res_fault` is 0.
- R3: With `mmu_en` low and `boot_mode` high, an instruction fetch returns `prom_base | VA[18:0]` with `res_prot` 3'b101. A data access in the same mode passes through as in R2.
- R4: The first read address is `(ctx_ptr << 4) + (ctx_num << 2)`. Each later read address is `(descriptor[31:2] << 6)` plus an index times 4. The index is VA[31:24] after the context word, VA[23:18] after a first-level pointer, and VA[17:12] after a second-level pointer.
- R5: Descriptor bits [1:0] give the type: 0 invalid, 1 pointer, 2 page entry, 3 reserved. A page entry at level 1, 2 or 3 gives `res_size` 2, 1 or 0 (16 MB, 256 KB, 4 KB). In that case `res_pa = (entry[31:8] << 12) + offset`, where the offset is VA[23:0], VA[17:0] or VA[11:0].
- R6: A walk fault reports `res_fault = (level << 8) | (type << 2)`, where the context word is level 0. Type 1 marks an invalid descriptor. Type 4 marks a reserved descriptor, a pointer at level 3, or a page entry in the context word. Any fault gives `res_pa` 0 and `res_prot` 0.
- R7: Entry bits [4:2] are the access field. A user access to field 6 or 7 faults with code 12. Otherwise code 8 is raised when the access lacks the right it needs: write needs W, instruction needs X, a plain read needs R. The rights per field are: user 0:R 1:RW 2:RX 3:RWX 4:X 5:R. Supervisor rights are the same except 5:RW, 6:RX and 7:RWX.
- R8: With `no_fault` high, a user permission fault is dropped and the translation completes with fault 0. Supervisor faults are never dropped.
- R9: Entry bit 5 is the referenced flag and bit 6 the modified flag. If bit 5 is clear, or the access is a write with bit 6 clear, the entry is written back to its own address. The written value has bit 5 set, and bit 6 set as well on a write. No write happens otherwise.
- R10: The W bit of `res_prot` is cleared unless the entry's modified flag is set after any write-back.
- R11: `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_valid` is high and `mem_ready` is low. Results do not depend on how long the memory stalls.
- R12: `done` is high for exactly one cycle per request. `req_ready` is low from acceptance until after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmu_en | input | 1 | Translation enable |
| boot_mode | input | 1 | Boot-ROM redirect for fetches when translation is off |
| no_fault | input | 1 | Suppress user permission faults |
| ctx_ptr | input | 32 | Context table pointer (physical address >> 4) |
| ctx_num | input | CTX_W | Context number |
| prom_base | input | PA_W | Boot ROM base address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_instr | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is supervisor |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | PA_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| res_pa | output | PA_W | Physical address |
| res_size | output | 2 | Page size: 0 4 KB, 1 256 KB, 2 16 MB |
| res_prot | output | 3 | Permission mask: bit0 R, bit1 W, bit2 X |
| res_fault | output | 10 | Fault code, 0 when the translation succeeds |

## Verification
The assertions watch the memory port on every cycle. They check that a stalled access keeps its address, direction and data, that every write-back carries the referenced flag, and that no access is issued while the walker is idle. They also check that `done` is a single-cycle strobe and that a faulting result carries no address or rights. The bench scenarios are the only place where the translation itself is shown: which words are fetched, the page size and offset at each level, the exact fault codes, the permission table, no-fault suppression, and the contents of write-backs. The same walk is repeated under a stalling memory to show that back-pressure leaves the result unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DW = 32;
  localparam int FAULT_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE
  } walk_st_e;

  localparam logic [1:0] DT_INVALID = 2'd0;
  localparam logic [1:0] DT_PTR     = 2'd1;
  localparam logic [1:0] DT_PTE     = 2'd2;
  localparam logic [1:0] DT_RSVD    = 2'd3;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  localparam logic [2:0] PRM_R = 3'b001;
  localparam logic [2:0] PRM_W = 3'b010;
  localparam logic [2:0] PRM_X = 3'b100;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_BAD     = 3'd4;

  localparam logic [3:0] PERR_PROT = 4'd8;
  localparam logic [3:0] PERR_PRIV = 4'd12;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [1:0]       lvl,
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [31:0]      va,
  input  logic [29:0]      desc_hi,
  output logic [PA_W-1:0]  addr
);
  localparam int TBL_SH = 4;

  logic [PA_W-1:0] ctx_base;
  logic [PA_W-1:0] tbl_base;
  logic [7:0]      idx;

  always_comb begin
    ctx_base = (PA_W'(ctx_ptr) << TBL_SH) + (PA_W'(ctx_num) << 2);
    tbl_base = PA_W'(desc_hi) << (TBL_SH + 2);
    case (lvl)
      2'd1:    idx = va[31:24];
      2'd2:    idx = {2'b00, va[23:18]};
      default: idx = {2'b00, va[17:12]};
    endcase
    addr = (lvl == 2'd0) ? ctx_base : tbl_base + (PA_W'(idx) << 2);
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [2:0] acc,
  input  logic       is_wr,
  input  logic       is_ins,
  input  logic       is_sup,
  output logic [2:0] perm,
  output logic [3:0] err
);
  logic [2:0] need;

  function automatic logic [2:0] user_rights(input logic [2:0] a);
    case (a)
      3'd0:    return PRM_R;
      3'd1:    return PRM_R | PRM_W;
      3'd2:    return PRM_R | PRM_X;
      3'd3:    return PRM_R | PRM_W | PRM_X;
      3'd4:    return PRM_X;
      3'd5:    return PRM_R;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] sup_rights(input logic [2:0] a);
    case (a)
      3'd5:    return PRM_R | PRM_W;
      3'd6:    return PRM_R | PRM_X;
      3'd7:    return PRM_R | PRM_W | PRM_X;
      default: return user_rights(a);
    endcase
  endfunction

  always_comb begin
    perm = is_sup ? sup_rights(acc) : user_rights(acc);
    need = (is_ins ? PRM_X : 3'b000) | (is_wr ? PRM_W : 3'b000) |
           ((!is_wr && !is_ins) ? PRM_R : 3'b000);
    if (!is_sup && acc[2:1] == 2'b11)
      err = PERR_PRIV;
    else if ((need & ~perm) != 3'b000)
      err = PERR_PROT;
    else
      err = 4'd0;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en,
  input  logic             boot_mode,
  input  logic             no_fault,
  input  logic [31:0]      ctx_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [PA_W-1:0]  prom_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic             req_write,
  input  logic             req_instr,
  input  logic             req_super,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             done,
  output logic [PA_W-1:0]  res_pa,
  output logic [1:0]       res_size,
  output logic [2:0]       res_prot,
  output logic [FAULT_W-1:0] res_fault
);
  localparam int BOOT_W = 19;
  localparam logic [1:0] LAST_LVL = 2'd3;

  walk_st_e            state_q;
  logic [1:0]          lvl_q;
  logic [31:0]         va_q;
  logic                wr_q, ins_q, sup_q;
  logic [PA_W-1:0]     addr_q;
  logic [DW-1:0]       wdata_q;
  logic [PA_W-1:0]     pa_q;
  logic [1:0]          size_q;
  logic [2:0]          prot_q;
  logic [FAULT_W-1:0]  fault_q;

  logic [1:0]          gen_lvl;
  logic [PA_W-1:0]     gen_addr;
  logic [2:0]          perm;
  logic [3:0]          perr;
  logic [1:0]          dtype;
  logic [DW-1:0]       upd_desc;
  logic                need_wb;
  logic [23:0]         offset;
  logic [PA_W-1:0]     page_pa;
  logic [2:0]          grant;
  logic                perm_fail;

  assign gen_lvl = (state_q == ST_IDLE) ? 2'd0 : lvl_q + 2'd1;

  ptw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .lvl     (gen_lvl),
    .ctx_ptr (ctx_ptr),
    .ctx_num (ctx_num),
    .va      (va_q),
    .desc_hi (mem_rdata[31:2]),
    .addr    (gen_addr)
  );

  ptw_perm u_perm (
    .acc    (mem_rdata[4:2]),
    .is_wr  (wr_q),
    .is_ins (ins_q),
    .is_sup (sup_q),
    .perm   (perm),
    .err    (perr)
  );

  function automatic logic [FAULT_W-1:0] fcode(input logic [1:0] l, input logic [2:0] t);
    return {l, 3'b000, t, 2'b00};
  endfunction

  always_comb begin
    dtype    = mem_rdata[1:0];
    upd_desc = mem_rdata | (DW'(1) << REF_BIT) | (wr_q ? (DW'(1) << MOD_BIT) : '0);
    need_wb  = !mem_rdata[REF_BIT] || (wr_q && !mem_rdata[MOD_BIT]);
    case (lvl_q)
      2'd1:    offset = va_q[23:0];
      2'd2:    offset = {6'd0, va_q[17:0]};
      default: offset = {12'd0, va_q[11:0]};
    endcase
    page_pa   = (PA_W'(mem_rdata[31:8]) << 12) + PA_W'(offset);
    grant     = upd_desc[MOD_BIT] ? perm : (perm & ~PRM_W);
    perm_fail = (perr != 4'd0) && !(no_fault && !sup_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ins_q   <= 1'b0;
      sup_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      prot_q  <= '0;
      fault_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          ins_q <= req_instr;
          sup_q <= req_super;
          lvl_q <= 2'd0;
          if (!mmu_en) begin
            size_q  <= 2'd0;
            fault_q <= '0;
            if (boot_mode && req_instr) begin
              pa_q   <= prom_base | PA_W'(req_va[BOOT_W-1:0]);
              prot_q <= PRM_R | PRM_X;
            end else begin
              pa_q   <= PA_W'(req_va);
              prot_q <= PRM_R | PRM_W | PRM_X;
            end
            state_q <= ST_DONE;
          end else begin
            addr_q  <= gen_addr;
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) begin
          if (dtype == DT_PTR && lvl_q != LAST_LVL) begin
            lvl_q   <= lvl_q + 2'd1;
            addr_q  <= gen_addr;
            state_q <= ST_RD_REQ;
          end else if (dtype == DT_PTE && lvl_q != 2'd0 && !perm_fail) begin
            pa_q    <= page_pa;
            size_q  <= LAST_LVL - lvl_q;
            prot_q  <= grant;
            fault_q <= '0;
            if (need_wb) begin
              wdata_q <= upd_desc;
              state_q <= ST_WR_REQ;
            end else begin
              state_q <= ST_DONE;
            end
          end else begin
            pa_q   <= '0;
            size_q <= '0;
            prot_q <= '0;
            if (dtype == DT_INVALID)
              fault_q <= fcode(lvl_q, FT_INVALID);
            else if (dtype == DT_PTE && lvl_q != 2'd0)
              fault_q <= FAULT_W'(perr);
            else
              fault_q <= fcode(lvl_q, FT_BAD);
            state_q <= ST_DONE;
          end
        end
        ST_WR_REQ: if (mem_ready) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign mem_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we    = (state_q == ST_WR_REQ);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign res_pa    = pa_q;
  assign res_size  = size_q;
  assign res_prot  = prot_q;
  assign res_fault = fault_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !done);

  // R9
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[REF_BIT]);

  // R6
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault != '0 |-> res_prot == 3'b000 && res_pa == '0);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int PA_W = 36;
  localparam int CTX_W = 8;
  localparam logic [PA_W-1:0] PROM = 36'hFFF000000;

  typedef struct packed {
    logic [31:0]     va;
    logic            wr, ins, sup, en, boot, nf;
    logic [7:0]      ctx;
    logic [PA_W-1:0] pa;
    logic [1:0]      size;
    logic [2:0]      prot;
    logic [9:0]      fault;
    logic [2:0]      nrd;
    logic            wb;
    logic [PA_W-1:0] wbaddr;
    logic [31:0]     wbdata;
    logic [3:0]      rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [0:NV-1] = '{
    // R5 16 MB page, offset VA[23:0]
    '{32'h01001234,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0AB001234,2'd2,3'd7,10'h000,3'd2,1'b0,36'h0,32'h0,4'd5},
    // R9 user write to a 4 KB page sets referenced and modified
    '{32'h00000ABC,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h000777ABC,2'd0,3'd3,10'h000,3'd4,1'b1,36'h40000,32'h00077766,4'd9},
    // R9 same page read again: no write-back
    '{32'h00000ABC,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h000777ABC,2'd0,3'd3,10'h000,3'd4,1'b0,36'h0,32'h0,4'd9},
    // R10 supervisor read of a clean 256 KB page: W withheld
    '{32'h00040010,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'd2,36'h012340010,2'd1,3'd1,10'h000,3'd3,1'b0,36'h0,32'h0,4'd10},
    // R7 user write to field 5: protection error
    '{32'h00040010,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h008,3'd3,1'b0,36'h0,32'h0,4'd7},
    // R9 supervisor write to field 5: modified set
    '{32'h00040010,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'd2,36'h012340010,2'd1,3'd3,10'h000,3'd3,1'b1,36'h30004,32'h01234076,4'd9},
    // R7 user read of field 6: privilege error
    '{32'h04000000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h00C,3'd2,1'b0,36'h0,32'h0,4'd7},
    // R9 supervisor fetch from field 6 sets referenced only
    '{32'h04000100,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'd2,36'h0CD000100,2'd2,3'd5,10'h000,3'd2,1'b1,36'h20010,32'h0CD0003A,4'd9},
    // R6 invalid at level 1
    '{32'h02000000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h104,3'd2,1'b0,36'h0,32'h0,4'd6},
    // R6 reserved at level 1
    '{32'h03000000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h110,3'd2,1'b0,36'h0,32'h0,4'd6},
    // R6 invalid at level 2
    '{32'h00080000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h204,3'd3,1'b0,36'h0,32'h0,4'd6},
    // R6 pointer at level 3
    '{32'h00001000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h310,3'd4,1'b0,36'h0,32'h0,4'd6},
    // R6 invalid at level 3
    '{32'h00002000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h304,3'd4,1'b0,36'h0,32'h0,4'd6},
    // R7 user read of execute-only page
    '{32'h00003008,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,36'h0,2'd0,3'd0,10'h008,3'd4,1'b0,36'h0,32'h0,4'd7},
    // R7 user fetch of execute-only page
    '{32'h00003008,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'd2,36'h000888008,2'd0,3'd4,10'h000,3'd4,1'b0,36'h0,32'h0,4'd7},
    // R8 no-fault mode drops user write error
    '{32'h00040020,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,8'd2,36'h012340020,2'd1,3'd1,10'h000,3'd3,1'b0,36'h0,32'h0,4'd8},
    // R8 no-fault mode keeps supervisor error
    '{32'h04000000,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,8'd2,36'h0,2'd0,3'd0,10'h008,3'd2,1'b0,36'h0,32'h0,4'd8},
    // R6 invalid context word
    '{32'h00000000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd3,36'h0,2'd0,3'd0,10'h004,3'd1,1'b0,36'h0,32'h0,4'd6},
    // R6 page entry in the context word
    '{32'h00000000,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd4,36'h0,2'd0,3'd0,10'h010,3'd1,1'b0,36'h0,32'h0,4'd6},
    // R2 bypass
    '{32'h87654321,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd2,36'h087654321,2'd0,3'd7,10'h000,3'd0,1'b0,36'h0,32'h0,4'd2},
    // R3 boot fetch redirect
    '{32'h12345678,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'd2,36'hFFF045678,2'd0,3'd5,10'h000,3'd0,1'b0,36'h0,32'h0,4'd3},
    // R3 boot-mode data access passes through
    '{32'h12345678,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd2,36'h012345678,2'd0,3'd7,10'h000,3'd0,1'b0,36'h0,32'h0,4'd3},
    // R4 level-1 index from VA[31:24]
    '{32'h0100FFFF,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'd2,36'h0AB00FFFF,2'd2,3'd7,10'h000,3'd2,1'b0,36'h0,32'h0,4'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmu_en = 1'b0, boot_mode = 1'b0, no_fault = 1'b0;
  logic [31:0] ctx_ptr = 32'h00001000;
  logic [CTX_W-1:0] ctx_num = 8'd2;
  logic [PA_W-1:0] prom_base = PROM;
  logic req_valid = 1'b0, req_write = 1'b0, req_instr = 1'b0, req_super = 1'b0;
  logic [31:0] req_va = '0;
  logic req_ready, mem_valid, mem_ready, mem_we, done;
  logic [PA_W-1:0] mem_addr, res_pa;
  logic [31:0] mem_wdata;
  logic mem_rvalid;
  logic [31:0] mem_rdata;
  logic [1:0] res_size;
  logic [2:0] res_prot;
  logic [9:0] res_fault;

  logic stall_mode = 1'b0;
  logic [31:0] cyc;
  int rd_cnt, wb_cnt;
  logic [PA_W-1:0] wb_addr;
  logic [31:0] wb_data;
  logic [31:0] mem [logic [35:0]];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ptw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) uut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .boot_mode(boot_mode),
    .no_fault(no_fault), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
    .prom_base(prom_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_instr(req_instr),
    .req_super(req_super), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .res_pa(res_pa), .res_size(res_size), .res_prot(res_prot),
    .res_fault(res_fault)
  );

  assign mem_ready = !stall_mode || cyc[1];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      rd_cnt <= 0; wb_cnt <= 0; wb_addr <= '0; wb_data <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wb_cnt <= wb_cnt + 1;
          wb_addr <= mem_addr;
          wb_data <= mem_wdata;
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string what, input int rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, output bit ok);
    int rd0, wb0, n;
    @(negedge clk);
    mmu_en = v.en; boot_mode = v.boot; no_fault = v.nf; ctx_num = v.ctx;
    req_va = v.va; req_write = v.wr; req_instr = v.ins; req_super = v.sup;
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    rd0 = rd_cnt; wb0 = wb_cnt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    ok = done;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R%0d watchdog: actual=no done expected=done", v.rq);
      return;
    end
    chk("pa", v.rq, 64'(res_pa), 64'(v.pa));
    chk("size", v.rq, 64'(res_size), 64'(v.size));
    chk("prot", v.rq, 64'(res_prot), 64'(v.prot));
    chk("fault", v.rq, 64'(res_fault), 64'(v.fault));
    chk("reads", v.rq, 64'(rd_cnt - rd0), 64'(v.nrd));
    chk("writebacks", v.rq, 64'(wb_cnt - wb0), 64'(v.wb));
    if (v.wb) begin
      chk("wb addr", v.rq, 64'(wb_addr), 64'(v.wbaddr));
      chk("wb data", v.rq, 64'(wb_data), 64'(v.wbdata));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 global watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    mem[36'h10008] = 32'h00002001;
    mem[36'h1000C] = 32'h00000000;
    mem[36'h10010] = 32'h00000002;
    mem[36'h20000] = 32'h00003001;
    mem[36'h20004] = 32'h0AB0006E;
    mem[36'h20008] = 32'h00000000;
    mem[36'h2000C] = 32'h00000003;
    mem[36'h20010] = 32'h0CD0001A;
    mem[36'h30000] = 32'h00004001;
    mem[36'h30004] = 32'h01234036;
    mem[36'h30008] = 32'h00000000;
    mem[36'h40000] = 32'h00077706;
    mem[36'h40004] = 32'h00005001;
    mem[36'h40008] = 32'h00000000;
    mem[36'h4000C] = 32'h00088872;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("reset req_ready", 1, 64'(req_ready), 64'd1);
    chk("reset done", 1, 64'(done), 64'd0);
    chk("reset mem_valid", 1, 64'(mem_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], ok);

    // R12 done lasts one cycle, walker idle afterwards
    @(negedge clk);
    chk("done pulse width", 12, 64'(done), 64'd0);
    chk("ready after done", 12, 64'(req_ready), 64'd1);

    // R12 request port closed during a walk
    mmu_en = 1'b1; no_fault = 1'b0; ctx_num = 8'd2;
    req_va = 32'h01001234; req_write = 1'b0; req_instr = 1'b0; req_super = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("busy ready", 12, 64'(req_ready), 64'd0);
    while (!done) @(negedge clk);
    chk("busy walk pa", 12, 64'(res_pa), 64'h0AB001234);

    // R11 same walks under a stalling memory
    stall_mode = 1'b1;
    run_vec(VECS[0], ok);
    run_vec(VECS[22], ok);
    run_vec(VECS[10], ok);
    stall_mode = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule